// File: doc/BRIEF.md
# Host Mailbox FIFO Bridge

This block connects a word-addressed host bus to a byte-wide link that leads to a small companion microcontroller. The host sends command bytes into a transmit FIFO, and the link drains that FIFO with a valid/ready handshake. Bytes that come back from the link are collected in a receive FIFO, and the host pulls them out by reading the data word.

Four FIFO conditions are visible in a status word:
- transmit FIFO empty
- transmit FIFO has room
- receive FIFO holds data
- receive FIFO dropped a byte

Each condition has a request flag and a mask bit in an interrupt word. The block drives a single interrupt line. Payload bytes sit in bits 15:8 of the data word in both directions.

Top module: `mbox_bridge`

## Requirements
- R1: After reset, the status word reads 0x3, the interrupt word reads 0x0, `irq` is 0 and `tx_valid` is 0.
- R2: The word addresses are 0 for the interrupt word, 1 for data and 2 for status. Addresses 3 to 7 read as zero, and writes to them change nothing.
- R3: A host write to the data word queues `bus_wdata[15:8]` in the transmit FIFO. Queued bytes appear on `tx_byte` with `tx_valid` in write order. A byte leaves the FIFO on a cycle where both `tx_valid` and `tx_ready` are high.
- R4: The transmit FIFO holds 8 bytes. While it is full, status bit 1 reads 0, and a host data write that is not met by a link pop in the same cycle is discarded.
- R5: A host read of the data word returns `{16'h0, head, 8'h00}` and pops the receive FIFO. If the receive FIFO is empty, the read returns 0.
- R6: The receive FIFO holds 8 bytes. A `rx_valid` cycle that finds it full drops the byte and sets status bit 3. The exception is a cycle in which the host also pops: then the byte is stored and no overflow is flagged.
- R7: Status bit 3 stays set until the host writes status with bit 3 set to one.
- R8: Status bits in order 0..3 are: transmit empty, transmit not full, receive not empty, overflow. Request bit k of the interrupt word rises on the clock edge after condition k goes from 0 to 1. A condition that simply stays high does not set the request again.
- R9: A write to the interrupt word loads bits 7:4 into the mask and clears every request bit in 3:0 written with one. If a request is being set in the same cycle, setting wins.
- R10: Writing a one to status bit k clears request bit k. Status bits 0 to 2 follow the FIFO state and are not changed by status writes.
- R11: `irq` is high exactly when some request bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data, valid in the cycle of the access |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO not empty |
| tx_ready | input | 1 | Link accepts `tx_byte` |
| rx_byte | input | 8 | Byte from the link |
| rx_valid | input | 1 | Push `rx_byte` into the receive FIFO |
| irq | output | 1 | Combined masked interrupt |

## Verification
Two collisions can happen in a single cycle.

The first is a link push arriving while the host reads the data word. With the receive FIFO full, the bench raises `rx_valid` in the same cycle as the data read. It then drains the FIFO through the scoreboard to show that the new byte was kept, and it checks that status bit 3 did not set.

The second is a request bit being set and cleared together. The bench writes a one to request bit 2 in exactly the cycle after the receive FIFO leaves empty, which is the cycle that bit gets set. A read of the interrupt word afterwards must still show the bit.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    localparam int BUS_W     = 32;
    localparam int ADDR_W    = 3;
    localparam int BYTE_W    = 8;
    localparam int NCOND     = 4;
    localparam int PAYLOAD_LO = 8;

    localparam logic [ADDR_W-1:0] WORD_IRQ  = 3'd0;
    localparam logic [ADDR_W-1:0] WORD_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] WORD_STAT = 3'd2;

    // bit order of a condition vector: 0 tx empty, 1 tx room, 2 rx data, 3 rx drop
    typedef struct packed {
        logic rx_drop;
        logic rx_data;
        logic tx_room;
        logic tx_empty;
    } cond_t;

    localparam cond_t COND_AT_RESET = '{rx_drop: 1'b0, rx_data: 1'b0,
                                        tx_room: 1'b1, tx_empty: 1'b1};

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } acc_kind_e;

    function automatic logic [BUS_W-1:0] place_payload(input logic [BYTE_W-1:0] b);
        logic [BUS_W-1:0] w;
        w = '0;
        w[PAYLOAD_LO +: BYTE_W] = b;
        return w;
    endfunction

    function automatic logic [BYTE_W-1:0] take_payload(input logic [BUS_W-1:0] w);
        return w[PAYLOAD_LO +: BYTE_W];
    endfunction

    function automatic logic [BUS_W-1:0] pack_irq_word(input logic [NCOND-1:0] msk,
                                                       input logic [NCOND-1:0] rq);
        logic [BUS_W-1:0] w;
        w = '0;
        w[NCOND +: NCOND] = msk;
        w[0 +: NCOND]     = rq;
        return w;
    endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full,
    output logic         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  store [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] level;
    logic          pop_ok, push_ok;

    assign empty   = (level == '0);
    assign full    = (level == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign dropped = push && !push_ok;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            store[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
    import mbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cond_t            cond,
    input  logic             wr_irq_word,
    input  logic [7:0]       wbyte,
    input  logic [NCOND-1:0] clr_from_stat,
    output logic [NCOND-1:0] req,
    output logic [NCOND-1:0] mask,
    output logic             irq
);
    logic [NCOND-1:0] cond_v, cond_prev, clr_any;

    assign cond_v  = cond;
    assign clr_any = (wr_irq_word ? wbyte[NCOND-1:0] : '0) | clr_from_stat;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond_prev <= COND_AT_RESET;
            mask      <= '0;
        end else begin
            cond_prev <= cond_v;
            if (wr_irq_word) begin
                mask <= wbyte[NCOND +: NCOND];
            end
        end
    end

    for (genvar k = 0; k < NCOND; k++) begin : g_req
        always_ff @(posedge clk) begin
            if (rst) begin
                req[k] <= 1'b0;
            end else if (cond_v[k] && !cond_prev[k]) begin
                req[k] <= 1'b1;
            end else if (clr_any[k]) begin
                req[k] <= 1'b0;
            end
        end
    end

    assign irq = |(req & mask);

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic              irq
);
    acc_kind_e        acc;
    logic             wr_irq_word, wr_data, wr_stat, rd_data;
    logic             tx_empty, tx_full, tx_drop_unused;
    logic             rx_empty, rx_full, rx_drop;
    logic [BYTE_W-1:0] rx_head;
    logic             ovf;
    logic [NCOND-1:0] req, mask, clr_stat;
    cond_t            cond;

    always_comb begin
        if (!bus_sel)    acc = ACC_NONE;
        else if (bus_we) acc = ACC_WRITE;
        else             acc = ACC_READ;
    end

    assign wr_irq_word = (acc == ACC_WRITE) && (bus_addr == WORD_IRQ);
    assign wr_data     = (acc == ACC_WRITE) && (bus_addr == WORD_DATA);
    assign wr_stat     = (acc == ACC_WRITE) && (bus_addr == WORD_STAT);
    assign rd_data     = (acc == ACC_READ)  && (bus_addr == WORD_DATA);

    mbox_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_txq (
        .clk     (clk),
        .rst     (rst),
        .push    (wr_data),
        .din     (take_payload(bus_wdata)),
        .pop     (tx_ready),
        .head    (tx_byte),
        .empty   (tx_empty),
        .full    (tx_full),
        .dropped (tx_drop_unused)
    );

    assign tx_valid = !tx_empty;

    mbox_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk     (clk),
        .rst     (rst),
        .push    (rx_valid),
        .din     (rx_byte),
        .pop     (rd_data),
        .head    (rx_head),
        .empty   (rx_empty),
        .full    (rx_full),
        .dropped (rx_drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf <= 1'b0;
        end else if (rx_drop) begin
            ovf <= 1'b1;
        end else if (wr_stat && bus_wdata[3]) begin
            ovf <= 1'b0;
        end
    end

    always_comb begin
        cond.tx_empty = tx_empty;
        cond.tx_room  = !tx_full;
        cond.rx_data  = !rx_empty;
        cond.rx_drop  = ovf;
    end

    assign clr_stat = wr_stat ? bus_wdata[NCOND-1:0] : '0;

    mbox_irq u_irq (
        .clk           (clk),
        .rst           (rst),
        .cond          (cond),
        .wr_irq_word   (wr_irq_word),
        .wbyte         (bus_wdata[7:0]),
        .clr_from_stat (clr_stat),
        .req           (req),
        .mask          (mask),
        .irq           (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (acc == ACC_READ) begin
            case (bus_addr)
                WORD_IRQ:  bus_rdata = pack_irq_word(mask, req);
                WORD_DATA: bus_rdata = rx_empty ? '0 : place_payload(rx_head);
                WORD_STAT: bus_rdata = {{(BUS_W-NCOND){1'b0}}, cond};
                default:   bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mbox_bridge_chk.sv
module mbox_bridge_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_sel,
    input logic        bus_we,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        tx_valid,
    input logic        tx_ready,
    input logic        rx_valid,
    input logic        irq,
    input logic        tx_full,
    input logic        rx_full,
    input logic        rx_empty,
    input logic        ovf,
    input logic [3:0]  req,
    input logic [3:0]  mask
);
    logic host_data_wr, host_data_rd, host_ovf_clr;

    assign host_data_wr = bus_sel && bus_we && (bus_addr == 3'd1);
    assign host_data_rd = bus_sel && !bus_we && (bus_addr == 3'd1);
    assign host_ovf_clr = bus_sel && bus_we && (bus_addr == 3'd2) && bus_wdata[3];

    assert_tx_full_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (host_data_wr && tx_full && !(tx_valid && tx_ready)) |=> tx_full);

    assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (host_data_rd && rx_empty) |-> (bus_rdata == 32'h0));

    assert_drop_sets_ovf_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_full && !host_data_rd) |=> ovf);

    assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf && !host_ovf_clr) |=> ovf);

    assert_req_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(!rx_empty) |=> req[2]);

    assert_irq_needs_mask_R11: assert property (@(posedge clk) disable iff (rst)
        (mask == 4'h0) |-> !irq);

endmodule

bind mbox_bridge mbox_bridge_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rx_valid  (rx_valid),
    .irq       (irq),
    .tx_full   (tx_full),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .ovf       (ovf),
    .req       (req),
    .mask      (mask)
);

// File: tb/test_mbox_bridge.sv
`timescale 1ns/1ps
module test_mbox_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #2 clk = ~clk;

    mbox_bridge i_mbox_bridge (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FIFO bridge FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic rx_push(input logic [7:0] b);
        rx_valid = 1'b1; rx_byte = b;
        if (rx_q.size() < 8) rx_q.push_back(b);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic rx_pop_chk(input string tag);
        logic [31:0] exp;
        exp = (rx_q.size() > 0) ? {16'h0, rx_q.pop_front(), 8'h00} : 32'h0;
        rd_chk(tag, 3'd1, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // transmit-side monitor: compares every handshake against the queue
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (!rst && tx_valid && tx_ready) begin
                if (tx_q.size() == 0) begin
                    chk("R3 unexpected tx byte", {24'h0, tx_byte}, 32'hFFFF_FFFF);
                end else begin
                    chk("R3 tx order", {24'h0, tx_byte}, {24'h0, tx_q.pop_front()});
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FIFO bridge FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd_chk("R1 status", 3'd2, 32'h3);
        rd_chk("R1 irq word", 3'd0, 32'h0);
        chk("R1 irq pin", {31'h0, irq}, 32'h0);
        chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);

        // R2 reserved words
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk("R2 reserved 3", 3'd3, 32'h0);
        rd_chk("R2 reserved 7", 3'd7, 32'h0);
        rd_chk("R2 irq after reserved write", 3'd0, 32'h0);
        rd_chk("R2 status after reserved write", 3'd2, 32'h3);

        wr(3'd0, 32'hF0);
        rd_chk("R9 mask load", 3'd0, 32'hF0);

        // R3 / R4 transmit path with link stalled
        for (int i = 0; i < 8; i++) begin
            wr(3'd1, {16'h0, 8'h10 + 8'(i), 8'h00});
            tx_q.push_back(8'h10 + 8'(i));
            if (i == 0) begin
                chk("R3 tx_valid", {31'h0, tx_valid}, 32'h1);
                chk("R3 tx head", {24'h0, tx_byte}, 32'h10);
            end
        end
        rd_chk("R4 status full", 3'd2, 32'h0);
        wr(3'd1, 32'h0000_EE00);
        rd_chk("R4 status after ignored write", 3'd2, 32'h0);
        rd_chk("R8 no request on falling", 3'd0, 32'hF0);
        tx_ready = 1'b1;
        idle(12);
        tx_ready = 1'b0;
        chk("R4 dropped byte never sent", tx_q.size(), 0);
        chk("R3 tx drained", {31'h0, tx_valid}, 32'h0);
        rd_chk("R8 tx requests", 3'd0, 32'hF3);
        chk("R11 irq high", {31'h0, irq}, 32'h1);
        wr(3'd0, 32'hF3);
        rd_chk("R9 w1c requests", 3'd0, 32'hF0);
        chk("R11 irq low", {31'h0, irq}, 32'h0);

        // R5 / R8 / R10 receive path
        rx_push(8'h51); rx_push(8'h52); rx_push(8'h53);
        rd_chk("R8 rx request", 3'd0, 32'hF4);
        rd_chk("R10 status live", 3'd2, 32'h7);
        wr(3'd2, 32'h4);
        rd_chk("R10 stat write clears request", 3'd0, 32'hF0);
        rd_chk("R10 status unchanged", 3'd2, 32'h7);
        idle(3);
        rd_chk("R8 level does not reassert", 3'd0, 32'hF0);
        for (int i = 0; i < 3; i++) rx_pop_chk("R5 rx data");
        rd_chk("R5 empty read zero", 3'd1, 32'h0);
        rd_chk("R5 status empty", 3'd2, 32'h3);

        // R6 / R7 overflow
        for (int i = 0; i < 8; i++) rx_push(8'h60 + 8'(i));
        rx_push(8'h99);
        rd_chk("R6 overflow flagged", 3'd2, 32'hF);
        rd_chk("R8 overflow request", 3'd0, 32'hFC);
        idle(4);
        rd_chk("R7 overflow sticky", 3'd2, 32'hF);
        wr(3'd2, 32'h8);
        rd_chk("R7 overflow cleared", 3'd2, 32'h7);
        rd_chk("R10 overflow request cleared", 3'd0, 32'hF4);
        wr(3'd0, 32'hF4);

        // R6 push and pop in the same cycle while full
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 3'd1;
        rx_valid = 1'b1; rx_byte = 8'h77;
        #1 v = bus_rdata;
        chk("R6 read during push", v, {16'h0, rx_q.pop_front(), 8'h00});
        rx_q.push_back(8'h77);
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0;
        rd_chk("R6 no overflow on push with pop", 3'd2, 32'h7);
        for (int i = 0; i < 8; i++) rx_pop_chk("R6 rx drain");
        rd_chk("R5 empty after drain", 3'd1, 32'h0);

        // R9 set wins over clear in the same cycle
        rx_push(8'h42);
        wr(3'd0, 32'hF4);
        rd_chk("R9 set beats clear", 3'd0, 32'hF4);

        // R11 masking
        wr(3'd0, 32'h00);
        rd_chk("R11 request kept, mask off", 3'd0, 32'h04);
        chk("R11 irq masked", {31'h0, irq}, 32'h0);
        wr(3'd0, 32'h40);
        chk("R11 irq unmasked", {31'h0, irq}, 32'h1);
        rx_pop_chk("R5 final byte");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule